// File: doc/BRIEF.md
# Byte-Wide Stream Cipher Keystream Generator

This block turns a key presented on a parallel bus into an RC4-style keystream, one byte at a time. Its state is a 256-entry byte permutation S held in a register array with one read port and one write port. After a restart, the permutation is first filled with the identity, S[k] = k. Key scheduling then runs i from 0 to 255 with j starting at 0. Each step sets j = (j + S[i] + key[i mod KEY_BYTES]) mod 256 and exchanges S[i] with S[j]. Generation then starts with i = j = 0. Each step sets i = i + 1 and j = j + S[i] (mod 256), exchanges S[i] with S[j], and produces S[(S[i] + S[j]) mod 256].

Every exchange is split into separate read and write cycles, so the array never needs more than one read and one write per clock. The case i = j comes out right with no extra logic. Progress is gated by a per-cycle enable, so the consumer can stall the engine on any cycle. A synchronous reset and a synchronous re-key input both restart the whole procedure from the key currently on the bus. Each new byte is marked by a single-cycle valid pulse. The XOR with the data stream is left to the consumer.

Top module: `keystream_gen`

## Requirements
- R1: The key bus is KEY_BYTES*8 bits wide, with KEY_BYTES a parameter (default 5). Key byte b (b = 0 is the first byte used) sits at bits [(KEY_BYTES-1-b)*8 +: 8], so the first byte is the most significant. Scheduling step i uses byte i mod KEY_BYTES. The key must be held stable from restart until scheduling ends.
- R2: When rst is high at a rising edge, the next cycle shows ks_valid = 0 and ks_byte = 0, and the fill/schedule procedure restarts from the current key, whatever the value of ena.
- R3: When rekey is high for one rising edge, it has the same effect as R2, whatever the value of ena. The byte stream that follows is identical to the stream that follows a reset with the same key.
- R4: In a cycle with ena low, the engine does not advance (its indices and phase stay the same) and no new byte appears. The byte sequence does not depend on the pattern of ena.
- R5: ks_valid is high for exactly one cycle per new byte and is never high in two consecutive cycles. ks_byte changes only in a cycle where ks_valid is high, or just after a restart, and otherwise holds its value.
- R6: No valid pulse is produced during fill or key scheduling. With ena held high from the release of a restart, ks_valid is first high after the 1028th rising edge: 256 fill cycles, 3×256 scheduling cycles, then 4 generation cycles.
- R7: With ena held high, consecutive valid pulses are exactly 4 cycles apart.
- R8: Every output byte equals the algorithm above. With KEY_BYTES = 5 and the ASCII key "gregg", bytes 1, 100, 1000 and 10000 are 0xee, 0xab, 0x90 and 0x28.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, restarts from the current key |
| rekey | input | 1 | Synchronous one-cycle re-key request |
| ena | input | 1 | Per-cycle advance enable |
| key | input | KEY_BYTES*8 | Key bytes, first byte in the most significant position |
| ks_byte | output | 8 | Current keystream byte |
| ks_valid | output | 1 | One-cycle strobe marking a new keystream byte |

## Verification
The bench builds two copies side by side. One uses KEY_BYTES = 5 with the key "gregg" and later a random key. This copy reaches the fixed checkpoint bytes up to the 10000th, and its long runs under random stalls exercise many i = j exchanges. The other uses KEY_BYTES = 3 with a random key. Three does not divide 256, so in this copy the key index wraps at a point that is not aligned to the end of scheduling, which tests the modulo-key walk. Both copies share enable, reset and re-key, so every stall and restart pattern is compared against the bench model for both key lengths at once.

// File: rtl/ksg_pkg.sv
package ksg_pkg;

  localparam int BYTE_W = 8;
  localparam int SBOX_N = 1 << BYTE_W;

  typedef logic [BYTE_W-1:0] sbyte_t;

  // phase encoding: generation phases occupy the upper half
  typedef enum logic [2:0] {
    ST_FILL   = 3'd0,
    ST_KS_RDI = 3'd1,
    ST_KS_RDJ = 3'd2,
    ST_KS_WRJ = 3'd3,
    ST_GN_RDI = 3'd4,
    ST_GN_RDJ = 3'd5,
    ST_GN_WRJ = 3'd6,
    ST_GN_OUT = 3'd7
  } ksg_state_e;

  // scheduling pointer update: j + S[i] + key byte, modulo 256
  function automatic sbyte_t ks_j_next(sbyte_t j, sbyte_t si, sbyte_t kb);
    return j + si + kb;
  endfunction

  // generation pointer update: j + S[i], modulo 256
  function automatic sbyte_t gen_j_next(sbyte_t j, sbyte_t si);
    return j + si;
  endfunction

  // output lookup index after the exchange
  function automatic sbyte_t out_index(sbyte_t si, sbyte_t sj);
    return si + sj;
  endfunction

  function automatic logic is_gen_phase(ksg_state_e s);
    return (s == ST_GN_RDI) || (s == ST_GN_RDJ) ||
           (s == ST_GN_WRJ) || (s == ST_GN_OUT);
  endfunction

  function automatic sbyte_t idx_inc(sbyte_t v);
    return v + sbyte_t'(1);
  endfunction

endpackage

// File: rtl/ksg_state_ram.sv
module ksg_state_ram #(
  parameter  int DW    = 8,
  parameter  int AW    = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // asynchronous read: the write of this cycle becomes visible next cycle
  assign rdata = mem[raddr];

endmodule

// File: rtl/ksg_key_sel.sv
module ksg_key_sel #(
  parameter  int KEY_BYTES = 5,
  parameter  int BW        = 8,
  localparam int KI_W      = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1,
  localparam int LANES     = 1 << KI_W
) (
  input  logic [KEY_BYTES*BW-1:0] key_bus,
  input  logic [KI_W-1:0]         sel,
  output logic [BW-1:0]           kbyte
);

  logic [BW-1:0] lane [LANES];

  // byte 0 of the key occupies the most significant lane of the bus
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g < KEY_BYTES) begin : g_used
      assign lane[g] = key_bus[(KEY_BYTES-1-g)*BW +: BW];
    end else begin : g_pad
      assign lane[g] = '0;
    end
  end

  assign kbyte = lane[sel];

endmodule

// File: rtl/ksg_seq.sv
module ksg_seq
  import ksg_pkg::*;
#(
  parameter  int KEY_BYTES = 5,
  localparam int KI_W      = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rekey,
  input  logic            ena,
  input  sbyte_t          key_byte,
  output logic [KI_W-1:0] key_sel,
  output sbyte_t          ram_raddr,
  input  sbyte_t          ram_rdata,
  output logic            ram_we,
  output sbyte_t          ram_waddr,
  output sbyte_t          ram_wdata,
  output sbyte_t          ks_byte,
  output logic            ks_valid,
  output ksg_state_e      st,
  output sbyte_t          idx_i,
  output sbyte_t          idx_j,
  output logic            ev_out,
  output logic            ev_gen
);

  localparam logic [KI_W-1:0] KI_LAST = KI_W'(KEY_BYTES - 1);

  ksg_state_e      state_q;
  sbyte_t          i_q, j_q, si_q, sj_q, dat_q;
  logic [KI_W-1:0] kidx_q;
  logic            vld_q;
  logic            restart, step;

  assign restart = rst | rekey;
  assign step    = ena & ~restart;

  // read address: one lookup per cycle
  always_comb begin
    unique case (state_q)
      ST_KS_RDI:            ram_raddr = i_q;
      ST_GN_RDI:            ram_raddr = idx_inc(i_q);
      ST_KS_RDJ, ST_GN_RDJ: ram_raddr = j_q;
      ST_GN_OUT:            ram_raddr = out_index(si_q, sj_q);
      default:              ram_raddr = i_q;
    endcase
  end

  // write port: fill, then two halves of each exchange
  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = i_q;
    ram_wdata = i_q;
    unique case (state_q)
      ST_FILL: begin
        ram_we    = step;
        ram_waddr = i_q;
        ram_wdata = i_q;
      end
      ST_KS_RDJ, ST_GN_RDJ: begin
        ram_we    = step;
        ram_waddr = i_q;
        ram_wdata = ram_rdata;
      end
      ST_KS_WRJ, ST_GN_WRJ: begin
        ram_we    = step;
        ram_waddr = j_q;
        ram_wdata = si_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (restart) begin
      state_q <= ST_FILL;
      i_q     <= '0;
      j_q     <= '0;
      si_q    <= '0;
      sj_q    <= '0;
      kidx_q  <= '0;
      dat_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (ena) begin
        unique case (state_q)
          ST_FILL: begin
            i_q <= idx_inc(i_q);
            if (&i_q) begin
              state_q <= ST_KS_RDI;
            end
          end
          ST_KS_RDI: begin
            si_q    <= ram_rdata;
            j_q     <= ks_j_next(j_q, ram_rdata, key_byte);
            state_q <= ST_KS_RDJ;
          end
          ST_KS_RDJ: begin
            state_q <= ST_KS_WRJ;
          end
          ST_KS_WRJ: begin
            kidx_q <= (kidx_q == KI_LAST) ? '0 : kidx_q + KI_W'(1);
            if (&i_q) begin
              i_q     <= '0;
              j_q     <= '0;
              state_q <= ST_GN_RDI;
            end else begin
              i_q     <= idx_inc(i_q);
              state_q <= ST_KS_RDI;
            end
          end
          ST_GN_RDI: begin
            i_q     <= idx_inc(i_q);
            si_q    <= ram_rdata;
            j_q     <= gen_j_next(j_q, ram_rdata);
            state_q <= ST_GN_RDJ;
          end
          ST_GN_RDJ: begin
            sj_q    <= ram_rdata;
            state_q <= ST_GN_WRJ;
          end
          ST_GN_WRJ: begin
            state_q <= ST_GN_OUT;
          end
          ST_GN_OUT: begin
            dat_q   <= ram_rdata;
            vld_q   <= 1'b1;
            state_q <= ST_GN_RDI;
          end
          default: state_q <= ST_FILL;
        endcase
      end
    end
  end

  assign key_sel  = kidx_q;
  assign ks_byte  = dat_q;
  assign ks_valid = vld_q;
  assign st       = state_q;
  assign idx_i    = i_q;
  assign idx_j    = j_q;
  assign ev_out   = step && (state_q == ST_GN_OUT);
  assign ev_gen   = is_gen_phase(state_q);

endmodule

// File: rtl/keystream_gen.sv
module keystream_gen
  import ksg_pkg::*;
#(
  parameter  int KEY_BYTES = 5,
  localparam int KEY_W     = KEY_BYTES * BYTE_W,
  localparam int KI_W      = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rekey,
  input  logic              ena,
  input  logic [KEY_W-1:0]  key,
  output logic [BYTE_W-1:0] ks_byte,
  output logic              ks_valid
);

  logic [KI_W-1:0] key_sel;
  sbyte_t          key_byte;
  sbyte_t          ram_raddr, ram_rdata, ram_waddr, ram_wdata;
  logic            ram_we;

  // named internal events, observed by the bound checker
  ksg_state_e      seq_state;
  sbyte_t          seq_i, seq_j;
  logic            ev_out, ev_gen;

  ksg_key_sel #(
    .KEY_BYTES (KEY_BYTES),
    .BW        (BYTE_W)
  ) u_key_sel (
    .key_bus (key),
    .sel     (key_sel),
    .kbyte   (key_byte)
  );

  ksg_state_ram #(
    .DW (BYTE_W),
    .AW (BYTE_W)
  ) u_sbox (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  ksg_seq #(
    .KEY_BYTES (KEY_BYTES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .rekey     (rekey),
    .ena       (ena),
    .key_byte  (key_byte),
    .key_sel   (key_sel),
    .ram_raddr (ram_raddr),
    .ram_rdata (ram_rdata),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata),
    .ks_byte   (ks_byte),
    .ks_valid  (ks_valid),
    .st        (seq_state),
    .idx_i     (seq_i),
    .idx_j     (seq_j),
    .ev_out    (ev_out),
    .ev_gen    (ev_gen)
  );

endmodule

// File: rtl/keystream_gen_chk.sv
module keystream_gen_chk
  import ksg_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       rekey,
  input logic       ena,
  input sbyte_t     ks_byte,
  input logic       ks_valid,
  input ksg_state_e st,
  input sbyte_t     idx_i,
  input sbyte_t     idx_j,
  input logic       ev_out,
  input logic       ev_gen
);

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (st == ST_FILL && idx_i == '0 && idx_j == '0 && !ks_valid && ks_byte == '0)); // R2

  AST_REKEY_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    rekey |=> (st == ST_FILL && idx_i == '0 && idx_j == '0 && !ks_valid && ks_byte == '0)); // R3

  AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (!ena && !rekey) |=> ($stable(st) && $stable(idx_i) && $stable(idx_j) && !ks_valid)); // R4

  AST_VALID_FOLLOWS_OUT: assert property (@(posedge clk) disable iff (rst)
    ev_out |=> ks_valid); // R5

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    ks_valid |=> !ks_valid); // R5

  AST_BYTE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$stable(ks_byte) |-> (ks_valid || $past(rekey) || $past(rst))); // R5

  AST_NO_VALID_IN_SCHED: assert property (@(posedge clk) disable iff (rst)
    !ev_gen |-> !ks_valid); // R6

endmodule

bind keystream_gen keystream_gen_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .rekey    (rekey),
  .ena      (ena),
  .ks_byte  (ks_byte),
  .ks_valid (ks_valid),
  .st       (seq_state),
  .idx_i    (seq_i),
  .idx_j    (seq_j),
  .ev_out   (ev_out),
  .ev_gen   (ev_gen)
);

// File: tb/keystream_gen_bench.sv
`timescale 1ns/1ps
module keystream_gen_bench;

  localparam int KB_A = 5;
  localparam int KB_B = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rekey = 1'b0;
  logic ena = 1'b0;
  logic [KB_A*8-1:0] key_a = '0;
  logic [KB_B*8-1:0] key_b = '0;
  logic [7:0] byte_a, byte_b;
  logic       vld_a, vld_b;

  int n_chk = 0;
  int n_fail = 0;

  int ref_s [2][256];
  int ref_i [2];
  int ref_j [2];
  int kbytes [2][8];
  int klen [2];
  int cnt [2];
  int prev_dat [2];
  bit prev_vld [2];
  bit gregg_a;

  always #2.5 clk = ~clk;

  keystream_gen #(.KEY_BYTES(KB_A)) u_keystream_gen (
    .clk(clk), .rst(rst), .rekey(rekey), .ena(ena), .key(key_a),
    .ks_byte(byte_a), .ks_valid(vld_a));

  keystream_gen #(.KEY_BYTES(KB_B)) u_keystream_gen_k3 (
    .clk(clk), .rst(rst), .rekey(rekey), .ena(ena), .key(key_b),
    .ks_byte(byte_b), .ks_valid(vld_b));

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model: modulo arithmetic written directly
  function automatic void ref_schedule(int u);
    int j = 0;
    for (int k = 0; k < 256; k++) ref_s[u][k] = k;
    for (int i = 0; i < 256; i++) begin
      int t;
      j = (j + ref_s[u][i] + kbytes[u][i % klen[u]]) % 256;
      t = ref_s[u][i]; ref_s[u][i] = ref_s[u][j]; ref_s[u][j] = t;
    end
    ref_i[u] = 0;
    ref_j[u] = 0;
  endfunction

  function automatic int ref_next(int u);
    int t;
    ref_i[u] = (ref_i[u] + 1) % 256;
    ref_j[u] = (ref_j[u] + ref_s[u][ref_i[u]]) % 256;
    t = ref_s[u][ref_i[u]];
    ref_s[u][ref_i[u]] = ref_s[u][ref_j[u]];
    ref_s[u][ref_j[u]] = t;
    return ref_s[u][(ref_s[u][ref_i[u]] + ref_s[u][ref_j[u]]) % 256];
  endfunction

  // R1: byte b of the key goes to bits [(N-1-b)*8 +: 8]
  task automatic pack_keys();
    for (int b = 0; b < KB_A; b++) key_a[(KB_A-1-b)*8 +: 8] = 8'(kbytes[0][b]);
    for (int b = 0; b < KB_B; b++) key_b[(KB_B-1-b)*8 +: 8] = 8'(kbytes[1][b]);
  endtask

  task automatic sample_all();
    bit v [2];
    int d [2];
    v[0] = vld_a; d[0] = int'(byte_a);
    v[1] = vld_b; d[1] = int'(byte_b);
    for (int u = 0; u < 2; u++) begin
      if (v[u]) begin
        int e;
        check(!prev_vld[u], "R5 valid two cycles in a row", 1, 0);
        cnt[u]++;
        e = ref_next(u);
        check(d[u] == e, (u == 0) ? "R4 stream byte under stalls" : "R1 three-byte key stream", d[u], e);
        if (u == 0 && gregg_a) begin
          if (cnt[0] == 1)     check(d[0] == 'hee, "R8 byte 1", d[0], 'hee);
          if (cnt[0] == 100)   check(d[0] == 'hab, "R8 byte 100", d[0], 'hab);
          if (cnt[0] == 1000)  check(d[0] == 'h90, "R8 byte 1000", d[0], 'h90);
          if (cnt[0] == 10000) check(d[0] == 'h28, "R8 byte 10000", d[0], 'h28);
        end
      end else begin
        check(d[u] == prev_dat[u], "R5 byte held between strobes", d[u], prev_dat[u]);
      end
      prev_dat[u] = d[u];
      prev_vld[u] = v[u];
    end
  endtask

  task automatic do_restart(bit hard, bit ena_val);
    @(negedge clk);
    if (hard) rst = 1'b1; else rekey = 1'b1;
    ena = ena_val;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    rekey = 1'b0;
    for (int u = 0; u < 2; u++) begin
      ref_schedule(u);
      cnt[u] = 0;
      prev_dat[u] = 0;
      prev_vld[u] = 1'b0;
    end
    check(!vld_a && byte_a == 8'h00, hard ? "R2 clear after reset" : "R3 clear after rekey",
          {vld_a, byte_a}, 0);
    check(!vld_b && byte_b == 8'h00, hard ? "R2 clear after reset" : "R3 clear after rekey",
          {vld_b, byte_b}, 0);
  endtask

  task automatic run_cycles(int n, int pct);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      sample_all();
      ena = ($urandom_range(0, 99) < pct);
    end
  endtask

  task automatic run_until(int target, int pct);
    while (cnt[0] < target) begin
      @(posedge clk);
      @(negedge clk);
      sample_all();
      ena = ($urandom_range(0, 99) < pct);
    end
  endtask

  task automatic edges_to_valid(output int edges);
    edges = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      edges++;
      sample_all();
    end while (!vld_a && edges < 3000);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", cnt[0], 0);
    summary();
  end

  initial begin
    string gk;
    int edges;
    int held;
    void'($urandom(32'h5eed_0c4a));
    gk = "gregg";
    klen[0] = KB_A;
    klen[1] = KB_B;
    for (int b = 0; b < KB_A; b++) kbytes[0][b] = int'(gk[b]);
    for (int b = 0; b < KB_B; b++) kbytes[1][b] = $urandom_range(0, 255);
    pack_keys();
    gregg_a = 1'b1;

    // reset state (R2)
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!vld_a && byte_a == 8'h00, "R2 reset state", {vld_a, byte_a}, 0);
    check(!vld_b && byte_b == 8'h00, "R2 reset state", {vld_b, byte_b}, 0);

    // latency and throughput with ena held high (R6, R7)
    do_restart(1'b1, 1'b1);
    ena = 1'b1;
    edges_to_valid(edges);
    check(edges == 1028, "R6 first strobe latency", edges, 1028);
    for (int k = 0; k < 2; k++) begin
      edges_to_valid(edges);
      check(edges == 4, "R7 strobe spacing", edges, 4);
    end

    // long stream with random stalls, checkpoint bytes (R4, R8)
    run_until(10000, 70);

    // long stall: nothing moves (R4)
    ena = 1'b0;
    held = cnt[0];
    run_cycles(40, 0);
    check(cnt[0] == held, "R4 no byte while stalled", cnt[0], held);

    // re-key while ena is low, stream restarts identically (R3)
    do_restart(1'b0, 1'b0);
    run_until(1000, 60);

    // reset during scheduling: no strobe (R6)
    do_restart(1'b1, 1'b1);
    run_cycles(600, 80);
    check(cnt[0] == 0, "R6 no strobe while scheduling", cnt[0], 0);

    // new key picked up by reset (R2, R1)
    gregg_a = 1'b0;
    for (int b = 0; b < KB_A; b++) kbytes[0][b] = $urandom_range(0, 255);
    for (int b = 0; b < KB_B; b++) kbytes[1][b] = $urandom_range(0, 255);
    pack_keys();
    do_restart(1'b1, 1'b1);
    run_until(400, 50);

    // re-key mid-stream with ena high (R3)
    do_restart(1'b0, 1'b1);
    run_until(200, 90);
    check(cnt[1] >= 200, "R1 three-byte instance kept pace", cnt[1], 200);

    summary();
  end

endmodule